// File: doc/BRIEF.md
# Filtered 4x Quadrature Decoder

This block turns the two raw channels of an incremental encoder into count and direction pulses for a position counter elsewhere on the chip. The raw channels arrive with no timing relation to the system clock. Each one is first brought into the clock domain through a short flop chain. It then passes a level-qualification filter, which lets a new level through only after that level has been seen on three clock edges in a row. Short noise spikes are removed this way.

The two filtered levels form a 2-bit Gray state, `{a, b}`. A registered step decoder compares this state with the state from the previous clock. When exactly one channel has moved, it issues a one-cycle count pulse and a direction flag, so there is one count for every edge on either channel (4x resolution). When both channels have moved in the same clock, the step is treated as illegal: no count is issued and a one-cycle error flag is raised instead.

After reset is released, the block spends a few cycles priming. During priming, the filter and the previous-state register load the levels currently present on the inputs, so an encoder resting at any position does not produce a false count. The path from a raw edge to the count pulse is fixed at six clock edges.

Top module: `quad_filt_decoder`

## Requirements
- R1: While rst_ni is low, cnt_o, dir_o, err_o, a_o and b_o are all 0.
- R2: After reset release with raw inputs held steady, a_o and b_o equal the raw levels after at most four rising edges, and no cnt_o or err_o pulse appears.
- R3: A raw level that lasts fewer than three clocks is ignored: a_o/b_o keep their value and no pulse is produced. A level that lasts three clocks or more is passed on.
- R4: An interrupted run of samples restarts qualification. The filtered level changes only after three consecutive equal samples of the synchronised input, counted from the last interruption.
- R5: Each filtered change of exactly one channel produces exactly one cnt_o pulse, one cycle wide.
- R6: The state is {A,B} with A as bit 1. The sequence 00→10→11→01→00 sets dir_o=1 (up) with the pulse, and the reverse sequence sets dir_o=0 (down).
- R7: A filtered change of both channels in the same clock produces no cnt_o and a single-cycle err_o.
- R8: cnt_o or err_o is high in the cycle after the sixth rising edge following a raw input change. This is within the limit of seven clocks.
- R9: cnt_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_raw_i | input | 1 | Raw encoder channel A (asynchronous) |
| b_raw_i | input | 1 | Raw encoder channel B (asynchronous) |
| cnt_o | output | 1 | One-cycle count enable |
| dir_o | output | 1 | Direction, 1 = up; valid with cnt_o |
| err_o | output | 1 | One-cycle flag for a two-channel step |
| a_o | output | 1 | Filtered level of channel A |
| b_o | output | 1 | Filtered level of channel B |

## Verification
The decoder is driven around a full Gray cycle in each direction. This shows that up and down steps are told apart, and that a repeated state produces nothing. Diagonal jumps in both directions check that a two-channel step raises err_o and does not count. On the filter side, raw pulses of two and three clocks mark the qualification threshold, a 2-1-held pattern shows that the run restarts after an interruption, and a reset with both inputs high shows that the block primes without a false count.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef logic [1:0] qstate_t;  // {A, B}

  localparam int unsigned CH_A = 1;
  localparam int unsigned CH_B = 0;

  // successor of s in the counting-up Gray order
  function automatic qstate_t step_up(qstate_t s);
    return {~s[CH_B], s[CH_A]};
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prime_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          lvl_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (prime_i) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else if (d_i != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= d_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;  // run broken: start over
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    prime_i,
  input  qstate_t st_i,
  output logic    cnt_o,
  output logic    dir_o,
  output logic    err_o
);
  qstate_t prev_q;
  qstate_t diff;
  logic    cnt_q, dir_q, err_q;

  assign diff = st_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= st_i;
      if (prime_i) begin
        cnt_q <= 1'b0;
        err_q <= 1'b0;
      end else begin
        cnt_q <= ^diff;
        err_q <= &diff;
        if (^diff) dir_q <= (st_i == step_up(prev_q));
      end
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
  assign err_o = err_q;
endmodule

// File: rtl/quad_filt_decoder.sv
module quad_filt_decoder
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_raw_i,
  input  logic b_raw_i,
  output logic cnt_o,
  output logic dir_o,
  output logic err_o,
  output logic a_o,
  output logic b_o
);
  // sync fill, one filter load, one decoder seed
  localparam int unsigned PRIME_LEN = SYNC_STAGES + 2;
  localparam int unsigned PW = $clog2(PRIME_LEN + 1);
  localparam logic [PW-1:0] PRIME_END = PW'(PRIME_LEN);

  logic [PW-1:0] prime_cnt_q;
  logic          prime;
  qstate_t       raw, sync_st, filt_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prime_cnt_q <= '0;
    else if (prime)  prime_cnt_q <= prime_cnt_q + 1'b1;
  end
  assign prime = (prime_cnt_q != PRIME_END);

  assign raw[CH_A] = a_raw_i;
  assign raw[CH_B] = b_raw_i;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (sync_st)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    qdec_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .prime_i(prime),
      .d_i    (sync_st[c]),
      .q_o    (filt_st[c])
    );
  end

  qdec_step u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prime_i(prime),
    .st_i   (filt_st),
    .cnt_o  (cnt_o),
    .dir_o  (dir_o),
    .err_o  (err_o)
  );

  assign a_o = filt_st[CH_A];
  assign b_o = filt_st[CH_B];
endmodule

// File: rtl/quad_filt_decoder_chk.sv
module quad_filt_decoder_chk #(
  parameter int unsigned FILT_LEN = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prime_i,
  input logic [1:0] sync_i,
  input logic       cnt_o,
  input logic       dir_o,
  input logic       err_o,
  input logic       a_o,
  input logic       b_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    ab, ab_d1, ab_d2, last_s;
  logic [CW-1:0] run_a, run_b;

  assign ab = {a_o, b_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_d1 <= '0; ab_d2 <= '0; last_s <= '0; run_a <= '0; run_b <= '0;
    end else begin
      ab_d1  <= ab;
      ab_d2  <= ab_d1;
      last_s <= sync_i;
      if (sync_i[1] != last_s[1]) run_a <= CW'(1);
      else if (run_a != CW'(FILT_LEN)) run_a <= run_a + 1'b1;
      if (sync_i[0] != last_s[0]) run_b <= CW'(1);
      else if (run_b != CW'(FILT_LEN)) run_b <= run_b + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !cnt_o && !err_o && !a_o && !b_o);

  // R3
  filt_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(prime_i) && a_o != $past(a_o)) |-> (run_a >= CW'(FILT_LEN) && last_s[1] == a_o));

  // R4
  filt_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(prime_i) && b_o != $past(b_o)) |-> (run_b >= CW'(FILT_LEN) && last_s[0] == b_o));

  // R5
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o |-> $countones(ab_d1 ^ ab_d2) == 1);

  // R6
  dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o |-> dir_o == (ab_d1 == {~ab_d2[0], ab_d2[1]}));

  // R7
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ab_d1 == ~ab_d2));

  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnt_o && err_o));
endmodule

bind quad_filt_decoder quad_filt_decoder_chk #(.FILT_LEN(FILT_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .prime_i(prime),
  .sync_i (sync_st),
  .cnt_o  (cnt_o),
  .dir_o  (dir_o),
  .err_o  (err_o),
  .a_o    (a_o),
  .b_o    (b_o)
);

// File: tb/quad_filt_decoder_tb.sv
module quad_filt_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_raw = 1'b0, b_raw = 1'b0;
  logic cnt, dir, err, a_f, b_f;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  quad_filt_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_raw_i(a_raw), .b_raw_i(b_raw),
    .cnt_o(cnt), .dir_o(dir), .err_o(err), .a_o(a_f), .b_o(b_f)
  );

  // {ab, exp_cnt, exp_dir, exp_err}
  localparam int NV = 14;
  localparam logic [4:0] VEC [NV] = '{
    5'b10_1_1_0, 5'b11_1_1_0, 5'b01_1_1_0, 5'b00_1_1_0,
    5'b01_1_0_0, 5'b11_1_0_0, 5'b10_1_0_0, 5'b00_1_0_0,
    5'b11_0_0_1, 5'b00_0_0_1, 5'b10_1_1_0, 5'b10_0_0_0,
    5'b01_0_0_1, 5'b11_1_0_0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe(input int n, output int nc, output int ne, output int lat,
                         output logic ldir, output int both);
    nc = 0; ne = 0; lat = 0; ldir = 1'bx; both = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (cnt && err) both++;
      if ((cnt || err) && lat == 0) lat = i;
      if (cnt) begin nc++; ldir = dir; end
      if (err) ne++;
    end
  endtask

  task automatic do_reset(input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; a_raw = a; b_raw = b;
    repeat (3) @(negedge clk);
    chk(!cnt && !dir && !err && !a_f && !b_f, "R1 reset outputs", {cnt, dir, err, a_f, b_f}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nc, ne, lat, both;
    logic ld;

    // R2: prime with inputs high, no false count
    do_reset(1'b1, 1'b1);
    observe(4, nc, ne, lat, ld, both);
    chk(a_f && b_f, "R2 levels after prime", {a_f, b_f}, 3);
    observe(8, nc, ne, lat, ld, both);
    chk(nc == 0 && ne == 0, "R2 no pulse after reset", nc + ne, 0);

    do_reset(1'b0, 1'b0);
    observe(10, nc, ne, lat, ld, both);

    // table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {a_raw, b_raw} = VEC[v][4:3];
      observe(12, nc, ne, lat, ld, both);
      chk(nc == int'(VEC[v][2]), $sformatf("R5 count pulses vec %0d", v), nc, VEC[v][2]);
      chk(ne == int'(VEC[v][0]), $sformatf("R7 error pulses vec %0d", v), ne, VEC[v][0]);
      chk(both == 0, "R9 exclusive", both, 0);
      if (VEC[v][2]) chk(ld == VEC[v][1], $sformatf("R6 direction vec %0d", v), ld, VEC[v][1]);
      if (VEC[v][2] || VEC[v][0]) chk(lat == 6, $sformatf("R8 latency vec %0d", v), lat, 6);
      chk({a_f, b_f} == VEC[v][4:3], "R3 filtered level", {a_f, b_f}, VEC[v][4:3]);
    end

    // R3: two-clock glitch ignored
    do_reset(1'b0, 1'b0);
    observe(8, nc, ne, lat, ld, both);
    a_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    a_raw = 1'b0;
    observe(12, nc, ne, lat, ld, both);
    chk(nc == 0 && ne == 0, "R3 2-clock glitch ignored", nc + ne, 0);
    chk(!a_f, "R3 level kept", a_f, 0);

    // R3: three-clock pulse passes, up then down
    @(negedge clk);
    a_raw = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    a_raw = 1'b0;
    observe(10, nc, ne, lat, ld, both);
    chk(nc == 2, "R3 3-clock pulse counted twice", nc, 2);
    chk(lat == 3, "R3 first pulse timing", lat, 3);
    chk(ld == 1'b0, "R6 last step down", ld, 0);

    // R4: 2 high, 1 low, then held high
    @(negedge clk);
    b_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    b_raw = 1'b0;
    @(negedge clk);
    b_raw = 1'b1;
    observe(12, nc, ne, lat, ld, both);
    chk(nc == 1, "R4 one count after restart", nc, 1);
    chk(lat == 6, "R4 latency from last change", lat, 6);
    chk(ld == 1'b0, "R6 00->01 is down", ld, 0);
    chk(b_f, "R4 level passed", b_f, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule